// File: doc/BRIEF.md
# Debug Register Access Guard

This block holds eight 64-bit debug registers and places permission logic in front of every read or write micro-operation aimed at them. A requester presents one operation per cycle: a valid strobe, a read/write select, a register index, write data, the current value of the destination register, and an operand size. Three mode inputs shape the check: a debug-extensions enable, a general-detect enable and a long-mode flag.

One cycle later the block returns a response. It gives either the destination value with the selected register merged into its low bytes, or the destination left untouched. It also raises at most one of three fault flags: invalid opcode, general protection, or debug exception. A faulting access never changes the register file. Breakpoint matching, status updates from real debug events and fault delivery are handled elsewhere.

Top module: `dbg_reg_guard`

## Requirements
- R1: An access with an index of 8 or above raises invalid opcode, whether debug extensions are on or off.
- R2: With debug extensions enabled, an access to index 4 or 5 raises invalid opcode.
- R3: With debug extensions disabled, index 4 reaches register 6 and index 5 reaches register 7, for both reads and writes.
- R4: A write to register 6 or 7 (including through the index 4 or 5 alias) whose data bits 63:32 are not all zero raises general protection when long mode is set. The same write completes normally when long mode is clear. The error code for this fault is 0, so the block has no port for it.
- R5: When no invalid-opcode or general-protection fault applies and general detect is set, the access raises debug exception instead of completing.
- R6: Priority order is invalid opcode, then general protection, then debug exception. Only the highest-ranked fault is reported.
- R7: A successful read returns the destination value with its low bytes replaced by the register value. The size code gives the number of bytes replaced: 1 replaces bits 7:0, 2 replaces bits 15:0, 4 replaces bits 31:0, and 8 or any other code replaces all 64 bits. Bits above the size are kept from the destination.
- R8: On any fault, the register file is not written and the returned data equals the destination value. A successful write also returns the destination value unchanged.
- R9: The response valid and the fault flags appear in the cycle after the request. At most one fault flag is high, and all flags are low when no request was made.
- R10: All registers reset to zero. A successful write is visible to a read in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | 4 | Requested register index (IDX_W) |
| req_wdata | input | 64 | Write data |
| req_dest | input | 64 | Current destination value for the merge |
| req_size | input | 4 | Operand size in bytes: 1, 2, 4 or 8 |
| cfg_dbg_ext | input | 1 | Debug extensions enabled |
| cfg_gen_detect | input | 1 | General-detect enabled |
| cfg_long_mode | input | 1 | Processor is in long mode |
| rsp_valid | output | 1 | Response valid, one cycle after req_valid |
| rsp_data | output | 64 | Merged or unchanged destination value |
| flt_ud | output | 1 | Invalid opcode fault |
| flt_gp | output | 1 | General protection fault |
| flt_db | output | 1 | Debug exception fault |

## Verification
The bench runs every combination of index (0 to 15), direction, debug-extensions, general-detect, long mode, zero or nonzero upper write data, and all four size codes back to back. This exposes each fault rule on its own and in every overlap, which separates the priority order from the individual checks. Reads that follow earlier writes tell aliased registers apart from their direct indices and show whether a faulted write left any trace. The size codes, used against a changing destination pattern, separate replaced bytes from kept bytes.

// File: rtl/dbg_guard_pkg.sv
package dbg_guard_pkg;

   typedef enum logic [1:0] {
      FLT_NONE = 2'd0,
      FLT_UD   = 2'd1,
      FLT_GP   = 2'd2,
      FLT_DB   = 2'd3
   } flt_e;

endpackage

// File: rtl/dbg_access_check.sv
module dbg_access_check
   import dbg_guard_pkg::*;
#(
   parameter int IDX_W    = 4,
   parameter int NUM_REGS = 8,
   parameter int HALF_W   = 32,
   localparam int PW      = $clog2(NUM_REGS)
) (
   input  logic              valid,
   input  logic              write,
   input  logic [IDX_W-1:0]  idx,
   input  logic [HALF_W-1:0] wdata_hi,
   input  logic              dbg_ext,
   input  logic              gen_detect,
   input  logic              long_mode,
   output flt_e              fault,
   output logic [PW-1:0]     phys_idx,
   output logic              wr_ok,
   output logic              rd_ok
);

   initial begin
      if (NUM_REGS != 8) $error("dbg_access_check: alias map assumes 8 registers");
      if (IDX_W < PW)    $error("dbg_access_check: index narrower than register file");
   end

   logic          out_of_range;
   logic [PW-1:0] low_idx;
   logic          is_alias_slot;
   logic          is_wide_chk;
   logic          ud, gp;

   generate
      if (IDX_W > PW) begin : g_wide_idx
         assign out_of_range = |idx[IDX_W-1:PW];
      end else begin : g_exact_idx
         assign out_of_range = 1'b0;
      end
   endgenerate

   assign low_idx       = idx[PW-1:0];
   assign is_alias_slot = !out_of_range &&
                          (low_idx == PW'(4) || low_idx == PW'(5));

   always_comb begin
      if (!dbg_ext && is_alias_slot) phys_idx = low_idx | PW'(2);
      else                           phys_idx = low_idx;
   end

   assign is_wide_chk = (phys_idx == PW'(6)) || (phys_idx == PW'(7));
   assign ud = out_of_range || (dbg_ext && is_alias_slot);
   assign gp = write && is_wide_chk && long_mode && (|wdata_hi);

   always_comb begin
      if (!valid)          fault = FLT_NONE;
      else if (ud)         fault = FLT_UD;
      else if (gp)         fault = FLT_GP;
      else if (gen_detect) fault = FLT_DB;
      else                 fault = FLT_NONE;
   end

   assign wr_ok = valid &&  write && (fault == FLT_NONE);
   assign rd_ok = valid && !write && (fault == FLT_NONE);

endmodule

// File: rtl/dbg_reg_file.sv
module dbg_reg_file #(
   parameter int NUM_REGS = 8,
   parameter int DATA_W   = 64,
   parameter logic [DATA_W-1:0] RESET_VAL = '0,
   localparam int PW = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PW-1:0]     wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [PW-1:0]     rd_idx,
   output logic [DATA_W-1:0] rd_data
);

   initial begin
      if (NUM_REGS < 2 || (1 << PW) != NUM_REGS)
         $error("dbg_reg_file: NUM_REGS must be a power of two");
   end

   logic [DATA_W-1:0] entry [NUM_REGS];

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
         always_ff @(posedge clk) begin
            if (!rst_n)                             entry[g] <= RESET_VAL;
            else if (wr_en && wr_idx == PW'(g))     entry[g] <= wr_data;
         end
      end
   endgenerate

   assign rd_data = entry[rd_idx];

endmodule

// File: rtl/dbg_size_merge.sv
module dbg_size_merge #(
   parameter int DATA_W = 64,
   parameter int SIZE_W = 4,
   localparam int NLANES = DATA_W / 8,
   localparam int CNT_W  = $clog2(NLANES + 1)
) (
   input  logic [DATA_W-1:0] src,
   input  logic [DATA_W-1:0] dest,
   input  logic [SIZE_W-1:0] size,
   output logic [DATA_W-1:0] merged
);

   initial begin
      if (DATA_W % 8 != 0 || DATA_W < 32)
         $error("dbg_size_merge: DATA_W must be a byte multiple of at least 32");
      if (SIZE_W < 3)
         $error("dbg_size_merge: size code too narrow");
   end

   logic [CNT_W-1:0] n_bytes;

   always_comb begin
      if (size == SIZE_W'(1))      n_bytes = CNT_W'(1);
      else if (size == SIZE_W'(2)) n_bytes = CNT_W'(2);
      else if (size == SIZE_W'(4)) n_bytes = CNT_W'(4);
      else                         n_bytes = CNT_W'(NLANES);
   end

   generate
      for (genvar l = 0; l < NLANES; l++) begin : g_lane
         assign merged[l*8 +: 8] = (CNT_W'(l) < n_bytes) ? src[l*8 +: 8]
                                                         : dest[l*8 +: 8];
      end
   endgenerate

endmodule

// File: rtl/dbg_reg_guard.sv
module dbg_reg_guard
   import dbg_guard_pkg::*;
#(
   parameter int IDX_W    = 4,
   parameter int DATA_W   = 64,
   parameter int NUM_REGS = 8,
   parameter int SIZE_W   = 4,
   localparam int PW      = $clog2(NUM_REGS),
   localparam int HALF_W  = DATA_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [IDX_W-1:0]  req_idx,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] req_dest,
   input  logic [SIZE_W-1:0] req_size,
   input  logic              cfg_dbg_ext,
   input  logic              cfg_gen_detect,
   input  logic              cfg_long_mode,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              flt_ud,
   output logic              flt_gp,
   output logic              flt_db
);

   initial begin
      if (DATA_W % 16 != 0) $error("dbg_reg_guard: DATA_W must split into byte halves");
   end

   flt_e              fault;
   logic [PW-1:0]     phys_idx;
   logic              wr_ok, rd_ok;
   logic [DATA_W-1:0] rf_rdata;
   logic [DATA_W-1:0] merged;

   dbg_access_check #(
      .IDX_W(IDX_W), .NUM_REGS(NUM_REGS), .HALF_W(HALF_W)
   ) u_check (
      .valid      (req_valid),
      .write      (req_write),
      .idx        (req_idx),
      .wdata_hi   (req_wdata[DATA_W-1:HALF_W]),
      .dbg_ext    (cfg_dbg_ext),
      .gen_detect (cfg_gen_detect),
      .long_mode  (cfg_long_mode),
      .fault      (fault),
      .phys_idx   (phys_idx),
      .wr_ok      (wr_ok),
      .rd_ok      (rd_ok)
   );

   dbg_reg_file #(
      .NUM_REGS(NUM_REGS), .DATA_W(DATA_W)
   ) u_file (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_ok),
      .wr_idx  (phys_idx),
      .wr_data (req_wdata),
      .rd_idx  (phys_idx),
      .rd_data (rf_rdata)
   );

   dbg_size_merge #(
      .DATA_W(DATA_W), .SIZE_W(SIZE_W)
   ) u_merge (
      .src    (rf_rdata),
      .dest   (req_dest),
      .size   (req_size),
      .merged (merged)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
         flt_ud    <= 1'b0;
         flt_gp    <= 1'b0;
         flt_db    <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         rsp_data  <= rd_ok ? merged : req_dest;
         flt_ud    <= (fault == FLT_UD);
         flt_gp    <= (fault == FLT_GP);
         flt_db    <= (fault == FLT_DB);
      end
   end

   // R9: response follows request by exactly one cycle
   a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid == $past(req_valid));

   // R9: never more than one fault flag, none without a request
   a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({flt_ud, flt_gp, flt_db}) && (rsp_valid || !(flt_ud || flt_gp || flt_db)));

   // R8: a faulted access hands back the destination untouched
   a_r8_dest_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_ud || flt_gp || flt_db) |-> rsp_data == $past(req_dest));

   // R4: protection fault only for a long-mode write
   a_r4_gp_cause: assert property (@(posedge clk) disable iff (!rst_n)
      flt_gp |-> $past(req_write && cfg_long_mode));

   // R5: debug exception only with general detect set
   a_r5_db_cause: assert property (@(posedge clk) disable iff (!rst_n)
      flt_db |-> $past(cfg_gen_detect));

   generate
      if (IDX_W > PW) begin : g_range_chk
         // R1: out-of-range index always traps as invalid opcode
         a_r1_range_ud: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && |req_idx[IDX_W-1:PW]) |=> flt_ud);
      end
   endgenerate

endmodule

// File: tb/dbg_reg_guard_tb.sv
`timescale 1ns/100ps
module dbg_reg_guard_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_write;
   logic [3:0]  req_idx;
   logic [63:0] req_wdata, req_dest;
   logic [3:0]  req_size;
   logic        cfg_dbg_ext, cfg_gen_detect, cfg_long_mode;
   logic        rsp_valid;
   logic [63:0] rsp_data;
   logic        flt_ud, flt_gp, flt_db;

   int total = 0;
   int fails = 0;
   bit done  = 0;
   logic [63:0] mdl [8];

   always #2.5 clk = ~clk;

   dbg_reg_guard u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_idx(req_idx), .req_wdata(req_wdata), .req_dest(req_dest),
      .req_size(req_size), .cfg_dbg_ext(cfg_dbg_ext),
      .cfg_gen_detect(cfg_gen_detect), .cfg_long_mode(cfg_long_mode),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .flt_ud(flt_ud), .flt_gp(flt_gp), .flt_db(flt_db)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] size_mask(input logic [3:0] sz);
      case (sz)
         4'd1:    return 64'h0000_0000_0000_00FF;
         4'd2:    return 64'h0000_0000_0000_FFFF;
         4'd4:    return 64'h0000_0000_FFFF_FFFF;
         default: return {64{1'b1}};
      endcase
   endfunction

   task automatic do_op(input logic wr, input logic [3:0] idx, input logic [63:0] wd,
                        input logic [63:0] dest, input logic [3:0] sz,
                        input logic ext, input logic gd, input logic lm);
      logic slot45, ud, gp, db;
      int   phys;
      logic [63:0] exp_data;
      string tag;
      slot45 = (idx == 4'd4 || idx == 4'd5);
      ud     = (idx >= 4'd8) || (ext && slot45);
      phys   = (!ext && slot45) ? int'(idx) + 2 : int'(idx[2:0]);
      gp     = !ud && wr && (phys >= 6) && lm && (wd[63:32] != 32'd0);
      db     = !ud && !gp && gd;
      if (!ud && !gp && !db && !wr)
         exp_data = (mdl[phys] & size_mask(sz)) | (dest & ~size_mask(sz));
      else
         exp_data = dest;
      if (idx >= 4'd8)               tag = "R1";
      else if (ext && slot45)        tag = "R2";
      else if (gp && gd)             tag = "R6";
      else if (gp)                   tag = "R4";
      else if (db)                   tag = "R5";
      else if (!ext && slot45)       tag = "R3";
      else if (wr)                   tag = "R10";
      else                           tag = "R7";

      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_idx = idx; req_wdata = wd;
      req_dest = dest; req_size = sz; cfg_dbg_ext = ext;
      cfg_gen_detect = gd; cfg_long_mode = lm;
      @(posedge clk);
      #1;
      check({tag, " flags"}, {60'd0, rsp_valid, flt_ud, flt_gp, flt_db},
            {60'd0, 1'b1, ud, gp, db});
      if (ud || gp || db) check("R8 dest kept on fault", rsp_data, exp_data);
      else                check({tag, " data"}, rsp_data, exp_data);
      if (!ud && !gp && !db && wr) mdl[phys] = wd;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      int n;
      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_idx = '0;
      req_wdata = '0; req_dest = '0; req_size = 4'd8;
      cfg_dbg_ext = 1'b0; cfg_gen_detect = 1'b0; cfg_long_mode = 1'b0;
      for (int i = 0; i < 8; i++) mdl[i] = '0;
      repeat (3) @(posedge clk);
      #1;
      // R9: quiet outputs in reset
      check("R9 reset flags", {60'd0, rsp_valid, flt_ud, flt_gp, flt_db}, 64'd0);
      @(negedge clk); rst_n = 1'b1;

      // R10: every register reads zero after reset
      for (int r = 0; r < 8; r++)
         do_op(1'b0, 4'(r), 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 4'd8, 1'b1, 1'b0, 1'b0);

      n = 0;
      for (int idx = 0; idx < 16; idx++)
         for (int wr = 0; wr < 2; wr++)
            for (int ext = 0; ext < 2; ext++)
               for (int lm = 0; lm < 2; lm++)
                  for (int hi = 0; hi < 2; hi++)
                     for (int gd = 0; gd < 2; gd++)
                        for (int s = 0; s < 4; s++) begin
                           logic [63:0] wd;
                           n++;
                           wd = {hi ? (32'hA500_0000 + 32'(n)) : 32'd0,
                                 32'h1234_0000 ^ 32'(n * 7)};
                           do_op(1'(wr), 4'(idx), wd,
                                 64'hFEDC_BA98_7654_3210 ^ {32'(n), 32'(n * 3)},
                                 4'(1 << s), 1'(ext), 1'(gd), 1'(lm));
                        end

      // R3 / R4: long-mode-free wide write through the alias, read back directly
      do_op(1'b1, 4'd5, 64'hDEAD_BEEF_0BAD_F00D, 64'd0, 4'd8, 1'b0, 1'b0, 1'b0);
      do_op(1'b0, 4'd7, 64'd0, 64'h1111_2222_3333_4444, 4'd8, 1'b1, 1'b0, 1'b1);
      // R10: other registers read back after the sweep
      for (int r = 0; r < 8; r++)
         do_op(1'b0, 4'(r), 64'd0, 64'h5555_AAAA_5555_AAAA, 4'd2, 1'b0, 1'b0, 1'b0);

      // R9: idle cycle gives no response and no fault
      @(negedge clk); req_valid = 1'b0; req_idx = 4'd9; cfg_gen_detect = 1'b1;
      @(posedge clk); #1;
      check("R9 idle", {60'd0, rsp_valid, flt_ud, flt_gp, flt_db}, 64'd0);

      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule